// File: doc/BRIEF.md
# Two-Phase Switching Cycle Synchronizer

This block produces the cycle-start strobes for two converter channels that switch half a period apart. Without an external clock it free-runs from a phase counter clocked by the fast system clock. One full switching period is `RATIO` system clocks. Channel 1 fires at phase zero and channel 2 at phase `RATIO/2`. With the defaults (an 180 MHz class clock and `RATIO` = 80) this gives the nominal 2.25 MHz per channel.

When a toggling clock arrives on the SYNC pin, the block samples it through a two-flop synchronizer and looks for falling edges. The edges are dealt out in turn: channel 1, then channel 2, then channel 1 again. Each channel therefore switches at half the SYNC rate. If the gap between falling edges is longer than the programmed `fallback_limit`, the external clock is too slow to be trusted, and the internal phase counter keeps control. The phase counter tracks every external strobe, so a loss of lock hands over to the internal timebase with the half-period spacing intact.

A SYNC level that stays put for longer than the same limit is decoded as a mode choice: high selects automatic PFM/PWM and low selects forced PWM. Each channel also has a low-output flag. While the flag is set, that channel passes only every third cycle start, which serves the start-up phase when the output is near zero.

Top module: `tps_clock_sync`

## Requirements
- R1: While reset is held, `cyc_start`, `ext_locked` and `pfm_mode` are all 0.
- R2: Unlocked, each channel strobes once every `RATIO` clocks, and channel 2 strobes `RATIO/2` clocks after channel 1. Each strobe is a single clock wide, and two strobes never occur in the same clock. `cyc_start` bit 0 is channel 1 and bit 1 is channel 2.
- R3: A qualifying SYNC falling edge raises its strobe in the clock that follows the third rising edge, counted from the first edge that samples the low SYNC level.
- R4: A falling edge whose gap from the previous falling edge is shorter than `fallback_limit` clocks sets `ext_locked` and strobes channel 1. A lone falling edge after a quiet SYNC neither locks nor strobes.
- R5: While locked, successive qualifying falling edges strobe channel 1 and channel 2 in strict alternation, and no internally timed strobe occurs.
- R6: When no falling edge arrives for `fallback_limit` clocks, `ext_locked` clears and internal timing resumes from the last external strobe. The next strobe goes to the other channel, `RATIO/2` clocks after that last strobe. This holds for `fallback_limit` ≤ `RATIO/2`−2.
- R7: A SYNC clock whose falling edges are further apart than `fallback_limit` never sets `ext_locked`, and the internal period of `RATIO` is undisturbed.
- R8: A synchronized SYNC level held for more than `fallback_limit` clocks is copied to `pfm_mode` (1 = PFM/PWM automatic, 0 = forced PWM). SYNC toggling faster than that leaves `pfm_mode` unchanged.
- R9: While `out_low[c]` is 1, channel c passes only every third cycle start, and the first one after the flag rises passes. The other channel is unaffected, and clearing the flag restores the full rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sync_in | input | 1 | Asynchronous SYNC pin: external clock or static mode level |
| out_low | input | NCH | Per-channel flag, output below the early-start level |
| fallback_limit | input | CNT_W | Edge gap and level hold limit, in clocks |
| cyc_start | output | NCH | One-clock cycle-start strobe per channel |
| ext_locked | output | 1 | Strobes are timed by SYNC falling edges |
| pfm_mode | output | 1 | Decoded static SYNC level |

## Verification
The bench drives SYNC on falling clock edges. Every SYNC strobe is expected exactly three sampling points after its falling edge, which covers two synchronizer flops plus the output register. The bench builds the expected channel for each cycle ahead of time and compares every cycle of the locked window against it. Internal timing is checked as exact differences of cycle stamps: `RATIO/2` between channels, `RATIO` per channel, three times that under a low-output flag, and `RATIO/2` from the last external strobe to the first internal one. Mode results are sampled only after `fallback_limit` plus a margin, or at a point inside a toggle burst where a level-following fault would already show.

// File: rtl/tps_pkg.sv
package tps_pkg;

  // lock and mode state handed from the monitor to the rest of the block
  typedef struct packed {
    logic locked;
    logic pfm;
  } tps_status_t;

  // modulo increment used for the channel pointer
  function automatic int wrap_inc(input int v, input int n);
    return (v >= n - 1) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/tps_sync_in.sv
module tps_sync_in #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic fall,
  output logic change
);
  logic [STAGES-1:0] sr;
  logic              prev;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sr[0] <= 1'b0;
          else        sr[0] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sr[s] <= 1'b0;
          else        sr[s] <= sr[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= sr[STAGES-1];

  assign level  = sr[STAGES-1];
  assign fall   = prev & ~level;
  assign change = prev ^ level;
endmodule

// File: rtl/tps_lock_mon.sv
module tps_lock_mon import tps_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             change,
  input  logic             level,
  input  logic [CNT_W-1:0] limit,
  output logic             ext_hit,
  output tps_status_t      status
);
  logic [CNT_W-1:0] gap_cnt;   // clocks since last falling edge, saturating
  logic [CNT_W-1:0] hold_cnt;  // clocks since last level change, saturating
  logic             gap_short;

  assign gap_short = gap_cnt < limit;
  assign ext_hit   = fall & gap_short;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gap_cnt       <= '1;
      status.locked <= 1'b0;
    end else begin
      if (fall)                gap_cnt <= '0;
      else if (gap_cnt < limit) gap_cnt <= gap_cnt + 1'b1;

      if (fall)                 status.locked <= gap_short;
      else if (gap_cnt >= limit) status.locked <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_cnt   <= '0;
      status.pfm <= 1'b0;
    end else begin
      if (change)                hold_cnt <= '0;
      else if (hold_cnt < limit) hold_cnt <= hold_cnt + 1'b1;

      if (!change && hold_cnt >= limit) status.pfm <= level;
    end
endmodule

// File: rtl/tps_phase_gen.sv
module tps_phase_gen import tps_pkg::*; #(
  parameter int RATIO = 80,
  parameter int NCH   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ext_hit,
  input  logic           locked,
  output logic [NCH-1:0] raw
);
  localparam int STEP = RATIO / NCH;
  localparam int PW   = $clog2(RATIO);
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1;

  logic [PW-1:0] ph;
  logic [IW-1:0] ptr;
  logic [IW-1:0] tgt;

  // first edge of a locked train always goes to channel 1
  assign tgt = locked ? ptr : '0;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      localparam logic [PW-1:0] POS = PW'(c * STEP);
      assign raw[c] = ext_hit ? (int'(tgt) == c) : (~locked && ph == POS);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph  <= '0;
      ptr <= '0;
    end else if (ext_hit) begin
      // realign the internal phase to the strobe just issued
      ph  <= PW'(int'(tgt) * STEP + 1);
      ptr <= IW'(wrap_inc(int'(tgt), NCH));
    end else begin
      ph  <= (ph == PW'(RATIO - 1)) ? '0 : ph + 1'b1;
    end
endmodule

// File: rtl/tps_rate_gate.sv
module tps_rate_gate #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic low,
  output logic stb
);
  localparam int DW = $clog2(DIV);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      stb <= 1'b0;
    end else begin
      stb <= raw & (~low | (cnt == '0));
      if (!low)     cnt <= '0;
      else if (raw) cnt <= (cnt == DW'(DIV - 1)) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/tps_clock_sync.sv
module tps_clock_sync import tps_pkg::*; #(
  parameter int RATIO       = 80,
  parameter int NCH         = 2,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int LOW_DIV     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [NCH-1:0]   out_low,
  input  logic [CNT_W-1:0] fallback_limit,
  output logic [NCH-1:0]   cyc_start,
  output logic             ext_locked,
  output logic             pfm_mode
);
  logic           sync_level, sync_fall, sync_change, ext_hit;
  tps_status_t    status;
  logic [NCH-1:0] raw;

  tps_sync_in #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sync_in),
    .level(sync_level), .fall(sync_fall), .change(sync_change)
  );

  tps_lock_mon #(.CNT_W(CNT_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .fall(sync_fall), .change(sync_change),
    .level(sync_level), .limit(fallback_limit),
    .ext_hit(ext_hit), .status(status)
  );

  tps_phase_gen #(.RATIO(RATIO), .NCH(NCH)) u_phase (
    .clk(clk), .rst_n(rst_n), .ext_hit(ext_hit),
    .locked(status.locked), .raw(raw)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_gate
      tps_rate_gate #(.DIV(LOW_DIV)) u_gate (
        .clk(clk), .rst_n(rst_n), .raw(raw[c]), .low(out_low[c]),
        .stb(cyc_start[c])
      );
    end
  endgenerate

  assign ext_locked = status.locked;
  assign pfm_mode   = status.pfm;
endmodule

// File: rtl/tps_clock_sync_chk.sv
module tps_clock_sync_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sync_level,
  input logic           sync_fall,
  input logic           ext_hit,
  input logic [NCH-1:0] cyc_start,
  input logic           ext_locked,
  input logic           pfm_mode
);
  // R2: never two channels in one clock
  a_r2_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cyc_start));

  // R4: lock is only ever gained on a synchronized falling edge
  a_r4_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_locked) |-> $past(sync_fall));

  // R4: gaining lock comes with a channel 1 strobe
  a_r4_lock_strobes_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_locked) |-> cyc_start[0]);

  // R5: while locked, only SYNC edges produce strobes
  a_r5_no_internal_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_locked && !ext_hit) |=> (cyc_start == '0));

  // R8: the mode output only ever takes the synchronized pin level
  a_r8_mode_from_level: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pfm_mode) |-> (pfm_mode == $past(sync_level)));
endmodule

bind tps_clock_sync tps_clock_sync_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_level(sync_level), .sync_fall(sync_fall),
  .ext_hit(ext_hit), .cyc_start(cyc_start), .ext_locked(ext_locked),
  .pfm_mode(pfm_mode)
);

// File: tb/tb_tps_clock_sync.sv
`timescale 1ns/100ps
module tb_tps_clock_sync;
  localparam int RATIO = 80;
  localparam int NCH   = 2;
  localparam int CNT_W = 16;
  localparam int STEP  = RATIO / NCH;
  localparam int LIM   = 30;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sync_in = 1'b0;
  logic [NCH-1:0]   out_low = '0;
  logic [CNT_W-1:0] fallback_limit = CNT_W'(LIM);
  logic [NCH-1:0]   cyc_start;
  logic             ext_locked;
  logic             pfm_mode;

  tps_clock_sync #(.RATIO(RATIO), .NCH(NCH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .out_low(out_low),
    .fallback_limit(fallback_limit), .cyc_start(cyc_start),
    .ext_locked(ext_locked), .pfm_mode(pfm_mode)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk  = 0;
  int n_fail = 0;
  int t_last_ext = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_stb(input int ch, input int maxc, output int t);
    t = -1;
    for (int k = 0; k < maxc; k++) begin
      @(negedge clk);
      if (cyc_start[ch]) begin t = cyc; return; end
    end
  endtask

  task automatic first_stb(input int maxc, output int ch, output int t);
    ch = -1; t = -1;
    for (int k = 0; k < maxc; k++) begin
      @(negedge clk);
      if (cyc_start != '0) begin ch = cyc_start[1] ? 1 : 0; t = cyc; return; end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 cyc_start in reset", int'(cyc_start), 0);
    check("R1 ext_locked in reset", int'(ext_locked), 0);
    check("R1 pfm_mode in reset", int'(pfm_mode), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_internal();
    int a, b, c, d;
    wait_stb(0, 3 * RATIO, a);
    wait_stb(1, 3 * RATIO, b);
    wait_stb(0, 3 * RATIO, c);
    wait_stb(1, 3 * RATIO, d);
    check("R2 ch2 offset from ch1", b - a, STEP);
    check("R2 ch1 period", c - a, RATIO);
    check("R2 ch2 period", d - b, RATIO);
  endtask

  task automatic t_mode_static();
    @(negedge clk); sync_in = 1'b1;
    repeat (LIM + 8) @(negedge clk);
    check("R8 static high gives PFM", int'(pfm_mode), 1);
    sync_in = 1'b0;
    repeat (LIM + 8) @(negedge clk);
    check("R8 static low gives forced PWM", int'(pfm_mode), 0);
    check("R4 lone falling edge does not lock", int'(ext_locked), 0);
  endtask

  task automatic t_ext_run();
    localparam int N = 64;
    int exp_ch [0:N+3];
    int m, stray, seen;
    for (int i = 0; i < N + 4; i++) exp_ch[i] = -1;
    m = 0;
    for (int i = 4; i < N; i += 8) begin
      if (m >= 1) exp_ch[i+3] = (m % 2 == 1) ? 0 : 1;
      m++;
    end
    stray = 0; seen = 0;
    for (int i = 0; i < N + 4; i++) begin
      @(negedge clk);
      if (i >= 15) begin
        if (exp_ch[i] >= 0) begin
          check($sformatf("R3 R5 strobe channel at step %0d", i),
                int'(cyc_start), 1 << exp_ch[i]);
          seen++;
          t_last_ext = cyc;
        end else if (cyc_start != '0) stray++;
      end
      if (i == 40) check("R4 locked during SYNC train", int'(ext_locked), 1);
      if (i == 36) check("R8 fast toggling keeps mode", int'(pfm_mode), 0);
      sync_in = (i < N) ? ((i % 8) < 4) : 1'b0;
    end
    check("R5 no extra strobes while locked", stray, 0);
    check("R5 external strobe count", seen, 7);
  endtask

  task automatic t_loss();
    int ch, t, t0;
    first_stb(2 * RATIO, ch, t);
    check("R6 first internal strobe channel", ch, 1);
    check("R6 first internal strobe spacing", t - t_last_ext, STEP);
    check("R6 lock dropped", int'(ext_locked), 0);
    wait_stb(0, 2 * RATIO, t0);
    check("R6 ch1 resumes one period later", t0 - t_last_ext, RATIO);
  endtask

  task automatic t_slow();
    int locks, a, b;
    locks = 0;
    for (int i = 0; i < 4 * RATIO; i++) begin
      @(negedge clk);
      if (ext_locked) locks++;
      sync_in = (i % RATIO) < (RATIO / 2);
    end
    check("R7 slow SYNC never locks", locks, 0);
    wait_stb(0, 3 * RATIO, a);
    wait_stb(0, 3 * RATIO, b);
    check("R7 internal period kept", b - a, RATIO);
  endtask

  task automatic t_third();
    int t0, a, b, c, d, e, f;
    @(negedge clk); out_low = 2'b01; t0 = cyc;
    wait_stb(0, 4 * RATIO, a);
    check("R9 first strobe after flag passes", int'(a - t0 <= RATIO), 1);
    wait_stb(0, 4 * RATIO, b);
    check("R9 low channel at one third rate", b - a, 3 * RATIO);
    wait_stb(1, 4 * RATIO, c);
    wait_stb(1, 4 * RATIO, d);
    check("R9 other channel unaffected", d - c, RATIO);
    @(negedge clk); out_low = 2'b00;
    wait_stb(0, 4 * RATIO, e);
    wait_stb(0, 4 * RATIO, f);
    check("R9 full rate after flag clears", f - e, RATIO);
  endtask

  initial begin
    t_reset();
    t_internal();
    t_mode_static();
    t_ext_run();
    t_loss();
    t_slow();
    t_third();
    finish_run();
  end

  initial begin
    #(100000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule